// File: doc/BRIEF.md
# MDIO Slave Management Register Bank

This block is the host-side register set that sits behind an MDIO slave frame engine. A host reaches it through a simple synchronous bus: one cycle strobes for read and write, a byte address, and 32-bit data. Read data comes from a register and is valid one clock after the read strobe. The frame engine reaches the same storage through a set of one-cycle event strobes. One event delivers the data of a completed write frame. One captures an output word for a read frame. A third reports protocol errors. The engine also receives the configuration fields back from the block.

Each of the 32 management addresses has two words behind it. The input word is written only by the frame engine, and the host can only read it. The output word is read and written by the host, and the engine sends it out. Per-address write and read event flags, three error flags and one combined interrupt line let software react to bus traffic. All flags are cleared by writing one to a clear register.

Top module: `mdio_mgmt_regs`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The control word at offset 0x00 holds enable (bit 0), write-event interrupt enable (bit 1), read-event interrupt enable (bit 2), error interrupt enable (bit 3), preamble-check bypass (bit 7) and port address (bits 12:8). The enable, bypass and port address fields also drive `cfg_en`, `cfg_bypass` and `cfg_port`.
- R2: While enable is 1, a host write to the control word leaves the port address and the bypass bit unchanged and updates the other fields. While enable is 0, one write sets all fields, including the write that sets enable.
- R3: With enable at 1, a frame write event for address n (n < 32) stores its 16-bit data in input word n, which reads at 0x100 + 4n. In the same clock edge it sets bit n of the write flag word at 0x04.
- R4: With enable at 1, a read capture for address n sets bit n of the read flag word at 0x0C. During the capture cycle, `fe_rd_data` shows output word n, which the host writes and reads at 0x180 + 4n.
- R5: A host write to output word n is dropped when it falls in the same cycle as a read capture of address n. A write to a different output word in that cycle takes effect.
- R6: Writing 1 to bit n of 0x08 clears write flag n, and writing 1 to bit n of 0x10 clears read flag n. Bits written as 0 leave their flags alone, and both clear registers read as zero.
- R7: The status word at 0x14 holds the preamble error (bit 0), start error (bit 1) and turnaround error (bit 2). These are set by `fe_err_evt` bits 0, 1 and 2 while enable is 1. Host writes to 0x14 have no effect. Writing 1 to a bit of 0x18 clears the matching error, and 0x18 reads as zero.
- R8: When a hardware set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high when any write flag is set with its interrupt enable, or any read flag is set with its interrupt enable, or any error flag is set with the error interrupt enable. Otherwise it is low.
- R10: While enable is 0, all input words are held at zero, and write, read and error events change no flag. Flags keep their values across a disable and a later re-enable.
- R11: Reserved control bits read as zero, and reads of unmapped offsets such as 0x1C and 0xFC return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 9 | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered, valid the cycle after `host_rd` |
| fe_wr_valid | input | 1 | Frame engine write event |
| fe_wr_addr | input | 5 | Management address of the write event |
| fe_wr_data | input | 16 | Data of the write event |
| fe_rd_cap | input | 1 | Frame engine read capture strobe |
| fe_rd_addr | input | 5 | Management address being captured |
| fe_rd_data | output | 16 | Output word selected by `fe_rd_addr` |
| fe_err_evt | input | 3 | Error events: bit 0 preamble, bit 1 start, bit 2 turnaround |
| cfg_en | output | 1 | Enable field |
| cfg_port | output | 5 | Port address field |
| cfg_bypass | output | 1 | Preamble-check bypass field |
| err_flags | output | 3 | Current error flags, same bit order as the status word |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that every frame engine strobe is high for a single cycle and that event addresses stay below 32. They also assume the host accesses only word-aligned offsets. The stimulus follows these rules: every strobe is driven for exactly one clock, addresses are drawn from 0 to 31, and host offsets are multiples of four. The random phase still places frame events and host clears in the same cycle, and puts host writes next to captures, so the ordering rules are exercised within those assumptions.

// File: rtl/mdio_regs_pkg.sv
// Package: offsets, field positions and the control record shared by the
// management register bank. Assumes a 9-bit byte address on the host bus.
package mdio_regs_pkg;
    localparam int HAW  = 9;     // host byte address width
    localparam int HDW  = 32;    // host data width
    localparam int IDXW = 5;     // management address width in a frame
    localparam int NERR = 3;     // preamble, start, turnaround

    localparam logic [HAW-1:0] OFF_CTRL = 9'h000;
    localparam logic [HAW-1:0] OFF_WFLG = 9'h004;
    localparam logic [HAW-1:0] OFF_WCLR = 9'h008;
    localparam logic [HAW-1:0] OFF_RFLG = 9'h00C;
    localparam logic [HAW-1:0] OFF_RCLR = 9'h010;
    localparam logic [HAW-1:0] OFF_STAT = 9'h014;
    localparam logic [HAW-1:0] OFF_ECLR = 9'h018;
    localparam logic [1:0]     WIN_DIN  = 2'b10;  // host_addr[8:7] for 0x100..0x17C
    localparam logic [1:0]     WIN_DOUT = 2'b11;  // host_addr[8:7] for 0x180..0x1FC

    localparam int B_EN   = 0;
    localparam int B_WIE  = 1;
    localparam int B_RIE  = 2;
    localparam int B_EIE  = 3;
    localparam int B_BYP  = 7;
    localparam int B_PORT = 8;

    typedef struct packed {
        logic [IDXW-1:0] port;
        logic            bypass;
        logic            err_ie;
        logic            rd_ie;
        logic            wr_ie;
        logic            en;
    } ctrl_t;

    // Lay the control record out at its host bit positions, reserved bits zero.
    function automatic logic [HDW-1:0] ctrl_word(ctrl_t c);
        logic [HDW-1:0] w;
        w = '0;
        w[B_EN]  = c.en;
        w[B_WIE] = c.wr_ie;
        w[B_RIE] = c.rd_ie;
        w[B_EIE] = c.err_ie;
        w[B_BYP] = c.bypass;
        w[B_PORT +: IDXW] = c.port;
        return w;
    endfunction
endpackage

// File: rtl/mdio_ctrl_reg.sv
// Control record register. Assumes one-cycle write strobes. Port address and
// bypass fields are frozen while the enable bit currently stored is 1.
module mdio_ctrl_reg
    import mdio_regs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [HDW-1:0] wdata,
    output ctrl_t          ctrl
);
    // Update the record; locked fields follow the current enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl.en     <= wdata[B_EN];
            ctrl.wr_ie  <= wdata[B_WIE];
            ctrl.rd_ie  <= wdata[B_RIE];
            ctrl.err_ie <= wdata[B_EIE];
            if (!ctrl.en) begin
                ctrl.bypass <= wdata[B_BYP];
                ctrl.port   <= wdata[B_PORT +: IDXW];
            end
        end
    end
endmodule

// File: rtl/mdio_flag_bank.sv
// Bank of N sticky event flags with write-one-to-clear. Assumes set and clear
// vectors are already qualified; a set in the same cycle as a clear wins.
module mdio_flag_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            // One flag: set dominates clear, otherwise hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[g] <= 1'b0;
                else if (set_vec[g])
                    flags[g] <= 1'b1;
                else if (clr_we && clr_vec[g])
                    flags[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/mdio_data_arrays.sv
// Input and output word arrays. Input words are written by qualified frame
// events and are held at zero while disabled. Output words take host writes
// unless a read capture of the same word happens in that cycle.
module mdio_data_arrays #(
    parameter int NREG = 32,
    parameter int DW   = 16,
    parameter int AW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_ev,
    input  logic [AW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             hw_we,
    input  logic [AW-1:0]    hw_idx,
    input  logic [DW-1:0]    hw_data,
    input  logic             cap,
    input  logic [AW-1:0]    cap_idx,
    output logic [NREG*DW-1:0] din_flat,
    output logic [NREG*DW-1:0] dout_flat,
    output logic [DW-1:0]    cap_data
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_word
            // Input word: cleared while disabled, loaded by a write event.
            always_ff @(posedge clk) begin
                if (!rst_n || !en)
                    din_flat[g*DW +: DW] <= '0;
                else if (wr_ev && wr_idx == AW'(g))
                    din_flat[g*DW +: DW] <= wr_data;
            end
            // Output word: host write, dropped on a same-word capture.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dout_flat[g*DW +: DW] <= '0;
                else if (hw_we && hw_idx == AW'(g) && !(cap && cap_idx == AW'(g)))
                    dout_flat[g*DW +: DW] <= hw_data;
            end
        end
    endgenerate

    // Select the output word addressed by the capture index.
    always_comb begin
        cap_data = '0;
        for (int i = 0; i < NREG; i++)
            if (cap_idx == AW'(i))
                cap_data = dout_flat[i*DW +: DW];
    end
endmodule

// File: rtl/mdio_mgmt_regs.sv
// Top of the management register bank. Decodes the host bus, qualifies frame
// engine events with enable, and muxes registered host read data. Assumes
// one-cycle strobes and word-aligned host offsets; NREG must not exceed 32.
module mdio_mgmt_regs
    import mdio_regs_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HAW-1:0]   host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [HDW-1:0]   host_wdata,
    output logic [HDW-1:0]   host_rdata,
    input  logic             fe_wr_valid,
    input  logic [IDXW-1:0]  fe_wr_addr,
    input  logic [DW-1:0]    fe_wr_data,
    input  logic             fe_rd_cap,
    input  logic [IDXW-1:0]  fe_rd_addr,
    output logic [DW-1:0]    fe_rd_data,
    input  logic [NERR-1:0]  fe_err_evt,
    output logic             cfg_en,
    output logic [IDXW-1:0]  cfg_port,
    output logic             cfg_bypass,
    output logic [NERR-1:0]  err_flags,
    output logic             irq
);
    localparam logic [IDXW:0] NREG_L = (IDXW+1)'(NREG);

    ctrl_t               ctrl;
    logic [NREG-1:0]     wr_flags, rd_flags, wr_set, rd_set;
    logic [NREG*DW-1:0]  din_flat, dout_flat;
    logic [IDXW-1:0]     hidx;
    logic                hidx_ok, in_din, in_dout, wr_ok, cap_ok;

    assign hidx    = host_addr[IDXW+1:2];
    assign hidx_ok = {1'b0, hidx} < NREG_L;
    assign in_din  = host_addr[8:7] == WIN_DIN  && host_addr[1:0] == 2'b00 && hidx_ok;
    assign in_dout = host_addr[8:7] == WIN_DOUT && host_addr[1:0] == 2'b00 && hidx_ok;
    assign wr_ok   = fe_wr_valid && ctrl.en && ({1'b0, fe_wr_addr} < NREG_L);
    assign cap_ok  = fe_rd_cap && ctrl.en && ({1'b0, fe_rd_addr} < NREG_L);

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_set
            assign wr_set[g] = wr_ok  && fe_wr_addr == IDXW'(g);
            assign rd_set[g] = cap_ok && fe_rd_addr == IDXW'(g);
        end
    endgenerate

    mdio_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_wr && host_addr == OFF_CTRL),
        .wdata (host_wdata),
        .ctrl  (ctrl)
    );

    mdio_flag_bank #(.N(NREG)) u_wflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (wr_set),
        .clr_we  (host_wr && host_addr == OFF_WCLR),
        .clr_vec (host_wdata[NREG-1:0]),
        .flags   (wr_flags)
    );

    mdio_flag_bank #(.N(NREG)) u_rflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (rd_set),
        .clr_we  (host_wr && host_addr == OFF_RCLR),
        .clr_vec (host_wdata[NREG-1:0]),
        .flags   (rd_flags)
    );

    mdio_flag_bank #(.N(NERR)) u_eflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (fe_err_evt & {NERR{ctrl.en}}),
        .clr_we  (host_wr && host_addr == OFF_ECLR),
        .clr_vec (host_wdata[NERR-1:0]),
        .flags   (err_flags)
    );

    mdio_data_arrays #(.NREG(NREG), .DW(DW), .AW(IDXW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.en),
        .wr_ev     (wr_ok),
        .wr_idx    (fe_wr_addr),
        .wr_data   (fe_wr_data),
        .hw_we     (host_wr && in_dout),
        .hw_idx    (hidx),
        .hw_data   (host_wdata[DW-1:0]),
        .cap       (fe_rd_cap),
        .cap_idx   (fe_rd_addr),
        .din_flat  (din_flat),
        .dout_flat (dout_flat),
        .cap_data  (fe_rd_data)
    );

    // Register the host read word; unmapped and clear offsets give zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= '0;
            if (in_din)
                host_rdata[DW-1:0] <= din_flat[hidx*DW +: DW];
            else if (in_dout)
                host_rdata[DW-1:0] <= dout_flat[hidx*DW +: DW];
            else if (host_addr == OFF_CTRL)
                host_rdata <= ctrl_word(ctrl);
            else if (host_addr == OFF_WFLG)
                host_rdata[NREG-1:0] <= wr_flags;
            else if (host_addr == OFF_RFLG)
                host_rdata[NREG-1:0] <= rd_flags;
            else if (host_addr == OFF_STAT)
                host_rdata[NERR-1:0] <= err_flags;
        end
    end

    assign cfg_en     = ctrl.en;
    assign cfg_port   = ctrl.port;
    assign cfg_bypass = ctrl.bypass;

    // Combine each flag class with its enable into the single interrupt.
    assign irq = (ctrl.wr_ie && |wr_flags) || (ctrl.rd_ie && |rd_flags) ||
                 (ctrl.err_ie && |err_flags);
endmodule

// File: rtl/mdio_mgmt_regs_chk.sv
// Checker for the management register bank, bound to the top. Assumes
// one-cycle strobes, event addresses below NREG and word-aligned host offsets.
module mdio_mgmt_regs_chk
    import mdio_regs_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HAW-1:0]     host_addr,
    input logic               host_wr,
    input logic               host_rd,
    input logic [HDW-1:0]     host_rdata,
    input logic               fe_wr_valid,
    input logic [IDXW-1:0]    fe_wr_addr,
    input logic               fe_rd_cap,
    input logic [IDXW-1:0]    fe_rd_addr,
    input logic [DW-1:0]      fe_rd_data,
    input logic [NERR-1:0]    fe_err_evt,
    input logic               cfg_en,
    input logic [IDXW-1:0]    cfg_port,
    input logic               cfg_bypass,
    input logic [NREG-1:0]    wr_flags,
    input logic [NREG-1:0]    rd_flags,
    input logic [NERR-1:0]    err_flags,
    input logic [NREG*DW-1:0] dout_flat,
    input logic               irq
);
    localparam logic [IDXW:0] NREG_L = (IDXW+1)'(NREG);

    logic [IDXW-1:0] wr_idx_q, rd_idx_q;
    logic [DW-1:0]   dout_at_rd_q;
    logic            in_din_rd, drop_case;

    // Remember last cycle's event addresses for the next-cycle checks.
    always_ff @(posedge clk) begin
        wr_idx_q <= fe_wr_addr;
        rd_idx_q <= fe_rd_addr;
    end

    assign dout_at_rd_q = dout_flat[rd_idx_q*DW +: DW];
    assign in_din_rd    = host_rd && host_addr[8:7] == WIN_DIN && host_addr[1:0] == 2'b00;
    assign drop_case    = host_wr && host_addr[8:7] == WIN_DOUT && host_addr[1:0] == 2'b00 &&
                          fe_rd_cap && host_addr[IDXW+1:2] == fe_rd_addr &&
                          ({1'b0, fe_rd_addr} < NREG_L);

    assert_ctrl_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en && host_wr && host_addr == OFF_CTRL |=>
        cfg_port == $past(cfg_port) && cfg_bypass == $past(cfg_bypass));

    assert_wr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fe_wr_valid && cfg_en && ({1'b0, fe_wr_addr} < NREG_L) |=> wr_flags[wr_idx_q]);

    assert_rd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fe_rd_cap && cfg_en && ({1'b0, fe_rd_addr} < NREG_L) |=> rd_flags[rd_idx_q]);

    assert_drop_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_case |=> dout_at_rd_q == $past(fe_rd_data));

    assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == OFF_ECLR |=> host_rdata == '0);

    assert_err_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en && fe_err_evt != '0 |=> (err_flags & $past(fe_err_evt)) == $past(fe_err_evt));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags == '0 && rd_flags == '0 && err_flags == '0 |-> !irq);

    assert_din_zero_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_din_rd && !cfg_en && !$past(cfg_en) |=> host_rdata == '0);

    assert_event_ignored_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en && fe_wr_valid && ({1'b0, fe_wr_addr} < NREG_L) && !wr_flags[fe_wr_addr]
        |=> !wr_flags[wr_idx_q]);
endmodule

bind mdio_mgmt_regs mdio_mgmt_regs_chk #(.NREG(NREG), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .fe_wr_valid (fe_wr_valid),
    .fe_wr_addr  (fe_wr_addr),
    .fe_rd_cap   (fe_rd_cap),
    .fe_rd_addr  (fe_rd_addr),
    .fe_rd_data  (fe_rd_data),
    .fe_err_evt  (fe_err_evt),
    .cfg_en      (cfg_en),
    .cfg_port    (cfg_port),
    .cfg_bypass  (cfg_bypass),
    .wr_flags    (wr_flags),
    .rd_flags    (rd_flags),
    .err_flags   (err_flags),
    .dout_flat   (dout_flat),
    .irq         (irq)
);

// File: tb/sim_mdio_mgmt_regs.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// requirement-level model kept in bench variables.
module sim_mdio_mgmt_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fe_wr_valid = 1'b0;
    logic [4:0]  fe_wr_addr = '0;
    logic [15:0] fe_wr_data = '0;
    logic        fe_rd_cap = 1'b0;
    logic [4:0]  fe_rd_addr = '0;
    logic [15:0] fe_rd_data;
    logic [2:0]  fe_err_evt = '0;
    logic        cfg_en, cfg_bypass, irq;
    logic [4:0]  cfg_port;
    logic [2:0]  err_flags;

    int tests = 0, fails = 0;

    // model state
    logic [15:0] m_din [32];
    logic [15:0] m_dout [32];
    logic [31:0] m_wrf = '0, m_rdf = '0;
    logic [2:0]  m_err = '0;
    logic [4:0]  m_port = '0;
    logic        m_byp = 0, m_wie = 0, m_rie = 0, m_eie = 0, m_en = 0;

    always #10 clk = ~clk;

    mdio_mgmt_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fe_wr_valid(fe_wr_valid), .fe_wr_addr(fe_wr_addr), .fe_wr_data(fe_wr_data),
        .fe_rd_cap(fe_rd_cap), .fe_rd_addr(fe_rd_addr), .fe_rd_data(fe_rd_data),
        .fe_err_evt(fe_err_evt), .cfg_en(cfg_en), .cfg_port(cfg_port),
        .cfg_bypass(cfg_bypass), .err_flags(err_flags), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(logic [8:0] a);
        if (a == 9'h000) return "R1";
        if (a == 9'h004) return "R3";
        if (a == 9'h00C) return "R4";
        if (a == 9'h014 || a == 9'h018) return "R7";
        if (a == 9'h008 || a == 9'h010) return "R6";
        if (a[8:7] == 2'b10) return "R3";
        if (a[8:7] == 2'b11) return "R5";
        return "R11";
    endfunction

    function automatic logic [31:0] model_read(logic [8:0] a);
        logic [31:0] w = '0;
        if (a == 9'h000) w = {19'b0, m_port, m_byp, 3'b0, m_eie, m_rie, m_wie, m_en};
        else if (a == 9'h004) w = m_wrf;
        else if (a == 9'h00C) w = m_rdf;
        else if (a == 9'h014) w = {29'b0, m_err};
        else if (a[8:7] == 2'b10 && a[1:0] == 0) w = {16'b0, m_din[a[6:2]]};
        else if (a[8:7] == 2'b11 && a[1:0] == 0) w = {16'b0, m_dout[a[6:2]]};
        return w;
    endfunction

    function automatic logic model_irq();
        return (m_wie && m_wrf != 0) || (m_rie && m_rdf != 0) || (m_eie && m_err != 0);
    endfunction

    // Advance the model by one clock edge from the inputs now driven.
    task automatic model_update();
        logic en0 = m_en;
        if (host_wr) begin
            if (host_addr == 9'h000) begin
                m_en = host_wdata[0]; m_wie = host_wdata[1];
                m_rie = host_wdata[2]; m_eie = host_wdata[3];
                if (!en0) begin m_byp = host_wdata[7]; m_port = host_wdata[12:8]; end
            end
            else if (host_addr == 9'h008) m_wrf &= ~host_wdata;
            else if (host_addr == 9'h010) m_rdf &= ~host_wdata;
            else if (host_addr == 9'h018) m_err &= ~host_wdata[2:0];
            else if (host_addr[8:7] == 2'b11 && host_addr[1:0] == 0)
                if (!(fe_rd_cap && fe_rd_addr == host_addr[6:2]))
                    m_dout[host_addr[6:2]] = host_wdata[15:0];
        end
        if (en0) begin
            if (fe_wr_valid) begin
                m_wrf[fe_wr_addr] = 1'b1;
                m_din[fe_wr_addr] = fe_wr_data;
            end
            if (fe_rd_cap) m_rdf[fe_rd_addr] = 1'b1;
            m_err |= fe_err_evt;
        end else begin
            for (int i = 0; i < 32; i++) m_din[i] = '0;
        end
    endtask

    // One clock with whatever is driven; checks read data, capture data, irq.
    task automatic step();
        logic        do_rd = host_rd;
        logic [8:0]  ra = host_addr;
        logic [31:0] exp_rd = model_read(host_addr);
        #1;
        if (fe_rd_cap) check("R4", {16'b0, fe_rd_data}, {16'b0, m_dout[fe_rd_addr]}, "capture data");
        model_update();
        @(posedge clk);
        @(negedge clk);
        if (do_rd) check(req_of(ra), host_rdata, exp_rd, $sformatf("read %h", ra));
        check("R9", {31'b0, irq}, {31'b0, model_irq()}, "irq");
        host_wr = 0; host_rd = 0; fe_wr_valid = 0; fe_rd_cap = 0; fe_err_evt = '0;
    endtask

    task automatic hwrite(logic [8:0] a, logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1; step();
    endtask
    task automatic hread(logic [8:0] a);
        host_addr = a; host_rd = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_din[i] = '0; m_dout[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", host_rdata, 32'h0, "reset rdata");
        check("R1", {31'b0, irq}, 32'h0, "reset irq");
        hread(9'h000);
        // R1 and R11: fields plus reserved bits 6:4 written as one
        hwrite(9'h000, 32'hFFFF_F5FF & 32'h0000_15FF);
        hread(9'h000);
        check("R1", {26'b0, cfg_port, cfg_bypass}, {26'b0, 5'h15, 1'b1}, "cfg outputs");
        // R2 locked port and bypass while enabled
        hwrite(9'h000, 32'h0000_0301);
        hread(9'h000);
        check("R2", {26'b0, cfg_port, cfg_bypass}, {26'b0, 5'h15, 1'b1}, "locked fields");
        hwrite(9'h000, 32'h0000_000F);
        // R11 unmapped
        hread(9'h01C);
        hread(9'h0FC);

        // R5 dropped write on same-word capture, other word in same cycle applies
        hwrite(9'h180 + 9'd20, 32'h0000_AAAA);
        host_addr = 9'h180 + 9'd20; host_wdata = 32'h5555; host_wr = 1;
        fe_rd_cap = 1; fe_rd_addr = 5'd5; step();
        host_addr = 9'h180 + 9'd20; host_wdata = 32'h1234; host_wr = 1;
        fe_rd_cap = 1; fe_rd_addr = 5'd5; step();
        hread(9'h180 + 9'd20);
        host_addr = 9'h180 + 9'd20; host_wdata = 32'h7777; host_wr = 1;
        fe_rd_cap = 1; fe_rd_addr = 5'd20; step();
        hread(9'h180 + 9'd20);
        hread(9'h00C);

        // R8 set beats clear for write, read and error flags
        fe_wr_valid = 1; fe_wr_addr = 5'd9; fe_wr_data = 16'hBEEF;
        host_addr = 9'h008; host_wdata = 32'hFFFF_FFFF; host_wr = 1; step();
        hread(9'h004);
        fe_rd_cap = 1; fe_rd_addr = 5'd3;
        host_addr = 9'h010; host_wdata = 32'hFFFF_FFFF; host_wr = 1; step();
        hread(9'h00C);
        fe_err_evt = 3'b010; host_addr = 9'h018; host_wdata = 32'h7; host_wr = 1; step();
        hread(9'h014);
        // R7 status write has no effect, clear reg reads zero
        hwrite(9'h014, 32'h0);
        hread(9'h014);
        hread(9'h018);
        hwrite(9'h018, 32'h2);
        hread(9'h014);
        // R6 clear with zero bits has no effect, clear reads zero
        hwrite(9'h008, 32'h0);
        hread(9'h004);
        hread(9'h008);
        hread(9'h010);

        // random phase
        for (int it = 0; it < 600; it++) begin
            int op = $urandom % 6;
            case (op)
                0: begin fe_wr_valid = 1; fe_wr_addr = 5'($urandom); fe_wr_data = 16'($urandom); end
                1: begin fe_rd_cap = 1; fe_rd_addr = 5'($urandom); end
                2: begin host_wr = 1; host_addr = {2'b11, 5'($urandom), 2'b00}; host_wdata = $urandom; end
                3: begin
                    int k = $urandom % 6;
                    host_rd = 1;
                    case (k)
                        0: host_addr = 9'h000;
                        1: host_addr = 9'h004;
                        2: host_addr = 9'h00C;
                        3: host_addr = 9'h014;
                        4: host_addr = {2'b10, 5'($urandom), 2'b00};
                        default: host_addr = {2'b11, 5'($urandom), 2'b00};
                    endcase
                end
                4: begin
                    int k = $urandom % 3;
                    host_wr = 1; host_wdata = $urandom;
                    host_addr = (k == 0) ? 9'h008 : (k == 1) ? 9'h010 : 9'h018;
                    if ($urandom % 2 == 1) begin
                        fe_wr_valid = 1; fe_wr_addr = 5'($urandom); fe_wr_data = 16'($urandom);
                    end
                end
                default: begin
                    fe_err_evt = 3'($urandom);
                    if ($urandom % 2 == 1) begin fe_rd_cap = 1; fe_rd_addr = 5'($urandom); end
                end
            endcase
            if ($urandom % 4 == 0 && !host_wr && !host_rd) begin
                host_rd = 1; host_addr = {2'b11, fe_rd_addr, 2'b00};
            end
            step();
            if (it == 300) hwrite(9'h000, 32'h0000_000B);
        end
        for (int i = 0; i < 32; i++) begin
            hread({2'b10, 5'(i), 2'b00});
            hread({2'b11, 5'(i), 2'b00});
        end
        hread(9'h004);
        hread(9'h00C);

        // R10 disable clears inputs, keeps flags, ignores events
        fe_wr_valid = 1; fe_wr_addr = 5'd7; fe_wr_data = 16'hC0DE; step();
        hwrite(9'h008, 32'hFFFF_FFFF);
        hwrite(9'h000, 32'h0000_000E);
        fe_wr_valid = 1; fe_wr_addr = 5'd7; fe_wr_data = 16'h1111; step();
        hread(9'h100 + 9'd28);
        check("R10", host_rdata, 32'h0, "input word 7 after disable");
        hread(9'h004);
        check("R10", host_rdata, 32'h0, "no flag while disabled");
        hread(9'h00C);
        fe_err_evt = 3'b111; step();
        hread(9'h014);
        hwrite(9'h000, 32'h0000_000F);
        hread(9'h00C);
        hread(9'h000);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule